// File: doc/BRIEF.md
# Byte-Port Seconds Counter with Alarm

This block keeps a free-running count of seconds in a multi-byte counter and makes that count available through a narrow register port. Each port access moves one byte, with no bursts. A one-second pulse comes in from outside, and the counter advances on it while the run bit is set. Software sets a new time by writing the upper bytes into a holding area. Those bytes reach the counter together with the low byte, at the moment the low byte is written. A time read returns the live counter bytes, so a reader that sees the low byte go down between two reads knows a carry happened and reads again.

An alarm register of the same width is compared with the counter on every cycle. A match sets a sticky status bit, provided the run bit and the alarm-arm bit are both set. The status bit drives the interrupt line directly, so the host sees one rising edge per event, and the line stays high until software clears the bit.

Top module: `byte_rtc`

## Requirements
- R1: After reset the counter, holding bytes, alarm value, control bits and status are all zero, the interrupt is low, and every offset reads 0x00.
- R2: Offset 0x00 is the control byte: bit 7 is run and bit 1 is alarm arm. A read returns those two bits as written, and every other bit reads 0.
- R3: On a `sec_tick` cycle with run set, the counter increments by one, and it wraps from 0xFFFFFFFF to 0. With run clear, ticks are ignored and the counter holds its value.
- R4: Offsets 0x06 to 0x09 return the live counter bytes, least-significant byte at 0x06. A read taken after a tick shows the new value.
- R5: Writes to offsets 0x03 to 0x05 only hold counter bytes 1 to 3, and the counter does not change. A write to offset 0x02 loads the counter with the held upper bytes and the written value as byte 0.
- R6: If a write to offset 0x02 and an enabled tick fall in the same cycle, the counter takes the loaded value and the tick is dropped.
- R7: Offsets 0x0A to 0x0D hold the alarm value, least-significant byte at 0x0A, and can be both written and read back.
- R8: When run and arm are both set and the counter equals the alarm value, the status bit (bit 0 of offset 0x01) is set on the next clock edge. The interrupt output is equal to the status bit.
- R9: Once set, the status bit stays set. A write to offset 0x01 with bit 0 equal to 0 clears it, and a write with bit 0 equal to 1 has no effect. If a match is present in the same cycle as a clear, the status bit stays set.
- R10: While run or arm is 0, a counter value equal to the alarm value does not set the status bit.
- R11: Writes to offsets 0x06 to 0x09, 0x0E and 0x0F change no state. Reads of 0x02 to 0x05, 0x0E and 0x0F return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DW | Write byte |
| bus_rdata | output | DW | Read byte (combinational from the offset) |
| alarm_irq | output | 1 | Alarm interrupt, level equal to the status bit |

## Verification
Two pairs of functions can land in the same cycle, and each is driven on purpose.

- **Load and tick:** the low-byte commit is written while `sec_tick` is held high with run set. The counter must then read back exactly the loaded value, not that value plus one.
- **Match and clear:** the counter is parked on the alarm value with run and arm set, and a status clear is written. The interrupt must stay high. After arm is dropped, the same clear must take the interrupt low one edge later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // fixed register offsets; the three byte windows follow WIN_BASE
    localparam logic [31:0] OFS_CTRL  = 32'd0;
    localparam logic [31:0] OFS_ALCTL = 32'd1;
    localparam logic [31:0] WIN_BASE  = 32'd2;

    // bit positions inside the control and alarm-control bytes
    localparam int CTL_RUN_BIT = 7;
    localparam int CTL_ARM_BIT = 1;
    localparam int ST_BIT      = 0;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_ALCTL,
        RG_TSET,
        RG_TGET,
        RG_ALVAL
    } rtc_region_e;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode import rtc_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4,
    parameter int IDX_W  = 2
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output rtc_region_e       region,
    output logic [IDX_W-1:0]  idx,
    output logic              ctl_wr,
    output logic              alctl_wr,
    output logic [NBYTES-1:0] tset_wr,
    output logic [NBYTES-1:0] alval_wr
);
    localparam logic [31:0] TSET_LO  = WIN_BASE;
    localparam logic [31:0] TGET_LO  = WIN_BASE + 32'(NBYTES);
    localparam logic [31:0] ALVAL_LO = WIN_BASE + 32'(2 * NBYTES);
    localparam logic [31:0] MAP_END  = WIN_BASE + 32'(3 * NBYTES);

    logic [31:0] a32;
    logic        wr;

    always_comb begin
        a32    = 32'(addr);
        region = RG_NONE;
        idx    = '0;
        if (a32 == OFS_CTRL) begin
            region = RG_CTRL;
        end else if (a32 == OFS_ALCTL) begin
            region = RG_ALCTL;
        end else if (a32 >= TSET_LO && a32 < TGET_LO) begin
            region = RG_TSET;
            idx    = IDX_W'(a32 - TSET_LO);
        end else if (a32 >= TGET_LO && a32 < ALVAL_LO) begin
            region = RG_TGET;
            idx    = IDX_W'(a32 - TGET_LO);
        end else if (a32 >= ALVAL_LO && a32 < MAP_END) begin
            region = RG_ALVAL;
            idx    = IDX_W'(a32 - ALVAL_LO);
        end
    end

    assign wr       = sel && we;
    assign ctl_wr   = wr && (region == RG_CTRL);
    assign alctl_wr = wr && (region == RG_ALCTL);

    for (genvar b = 0; b < NBYTES; b++) begin : g_stb
        assign tset_wr[b]  = wr && (region == RG_TSET)  && (idx == IDX_W'(b));
        assign alval_wr[b] = wr && (region == RG_ALVAL) && (idx == IDX_W'(b));
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int NBYTES = 4,
    parameter int DW     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic                         tick,
    input  logic [DW-1:0]                wdata,
    input  logic [NBYTES-1:0]            tset_wr,
    output logic [NBYTES-1:0][DW-1:0]    cnt
);
    localparam int CNT_W = NBYTES * DW;

    typedef struct packed {
        logic [NBYTES-1:1][DW-1:0] stage;
        logic [NBYTES-1:0][DW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 1; b < NBYTES; b++) begin
            if (tset_wr[b]) st_d.stage[b] = wdata;
        end
        // a byte-0 write commits and takes precedence over a tick
        if (tset_wr[0]) begin
            st_d.cnt = {st_q.stage, wdata};
        end else if (run && tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm import rtc_pkg::*; #(
    parameter int NBYTES = 4,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      arm,
    input  logic [NBYTES-1:0][DW-1:0] cnt,
    input  logic [DW-1:0]             wdata,
    input  logic [NBYTES-1:0]         alval_wr,
    input  logic                      clr_wr,
    output logic [NBYTES-1:0][DW-1:0] alval,
    output logic                      status
);
    typedef struct packed {
        logic [NBYTES-1:0][DW-1:0] alval;
        logic                      status;
    } al_state_t;

    al_state_t st_d, st_q;
    logic      hit;

    assign hit = run && arm && (cnt == st_q.alval);

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (alval_wr[b]) st_d.alval[b] = wdata;
        end
        if (clr_wr && !wdata[ST_BIT]) st_d.status = 1'b0;
        // a live match beats a clear so no event is lost
        if (hit) st_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alval  = st_q.alval;
    assign status = st_q.status;
endmodule

// File: rtl/byte_rtc.sv
module byte_rtc import rtc_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int DW     = 8,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              alarm_irq
);
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        logic run;
        logic arm;
    } ctl_t;

    rtc_region_e               region;
    logic [IDX_W-1:0]          ridx;
    logic                      ctl_wr;
    logic                      alctl_wr;
    logic [NBYTES-1:0]         tset_wr;
    logic [NBYTES-1:0]         alval_wr;
    logic [NBYTES-1:0][DW-1:0] cnt_bytes;
    logic [NBYTES-1:0][DW-1:0] alarm_bytes;
    logic                      status;
    logic                      run_en;
    logic                      arm_en;
    logic [DW-1:0]             ctl_byte;
    logic [DW-1:0]             alctl_byte;
    ctl_t                      ctl_d, ctl_q;

    rtc_bus_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_dec (
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .region   (region),
        .idx      (ridx),
        .ctl_wr   (ctl_wr),
        .alctl_wr (alctl_wr),
        .tset_wr  (tset_wr),
        .alval_wr (alval_wr)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.run = bus_wdata[CTL_RUN_BIT];
            ctl_d.arm = bus_wdata[CTL_ARM_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign run_en = ctl_q.run;
    assign arm_en = ctl_q.arm;

    rtc_counter #(.NBYTES(NBYTES), .DW(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_en),
        .tick    (sec_tick),
        .wdata   (bus_wdata),
        .tset_wr (tset_wr),
        .cnt     (cnt_bytes)
    );

    rtc_alarm #(.NBYTES(NBYTES), .DW(DW)) u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .arm      (arm_en),
        .cnt      (cnt_bytes),
        .wdata    (bus_wdata),
        .alval_wr (alval_wr),
        .clr_wr   (alctl_wr),
        .alval    (alarm_bytes),
        .status   (status)
    );

    always_comb begin
        ctl_byte                 = '0;
        ctl_byte[CTL_RUN_BIT]    = ctl_q.run;
        ctl_byte[CTL_ARM_BIT]    = ctl_q.arm;
        alctl_byte               = '0;
        alctl_byte[ST_BIT]       = status;
        case (region)
            RG_CTRL:  bus_rdata = ctl_byte;
            RG_ALCTL: bus_rdata = alctl_byte;
            RG_TGET:  bus_rdata = cnt_bytes[ridx];
            RG_ALVAL: bus_rdata = alarm_bytes[ridx];
            default:  bus_rdata = '0;
        endcase
    end

    assign alarm_irq = status;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk import rtc_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int DW     = 8,
    parameter int NBYTES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sec_tick,
    input logic                      bus_sel,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DW-1:0]             bus_wdata,
    input logic [DW-1:0]             bus_rdata,
    input logic                      alarm_irq,
    input logic [NBYTES-1:0][DW-1:0] cnt_bytes,
    input logic [NBYTES-1:0][DW-1:0] alarm_bytes,
    input logic                      run_en,
    input logic                      arm_en
);
    localparam int          CNT_W   = NBYTES * DW;
    localparam logic [31:0] MAP_END = WIN_BASE + 32'(3 * NBYTES);

    logic load0;
    logic clr;
    assign load0 = bus_sel && bus_we && (32'(bus_addr) == WIN_BASE);
    assign clr   = bus_sel && bus_we && (32'(bus_addr) == OFS_ALCTL) && !bus_wdata[ST_BIT];

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load0) |=> $stable(cnt_bytes));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && sec_tick && !load0) |=> (CNT_W'(cnt_bytes) == CNT_W'($past(cnt_bytes)) + CNT_W'(1)));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load0 |=> (cnt_bytes[0] == $past(bus_wdata)));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(run_en && arm_en && (cnt_bytes == alarm_bytes)));

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_irq) |-> $past(clr));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (32'(bus_addr) >= MAP_END)) |-> (bus_rdata == '0));
endmodule

bind byte_rtc rtc_chk #(.ADDR_W(ADDR_W), .DW(DW), .NBYTES(NBYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .alarm_irq   (alarm_irq),
    .cnt_bytes   (cnt_bytes),
    .alarm_bytes (alarm_bytes),
    .run_en      (run_en),
    .arm_en      (arm_en)
);

// File: tb/tb_byte_rtc.sv
`timescale 1ns/1ps
module tb_byte_rtc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int nvec = 0;
    int nerr = 0;

    byte_rtc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd32(input logic [3:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(base + 4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic set_time(input logic [31:0] v);
        wr(4'h2, 8'h00);
        wr(4'h3, v[15:8]);
        wr(4'h4, v[23:16]);
        wr(4'h5, v[31:24]);
        wr(4'h2, v[7:0]);
    endtask

    task automatic set_alarm(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'hA + 4'(i), v[i*8 +: 8]);
    endtask

    task automatic tick1();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        logic [63:0] start;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: every offset reads zero after reset, irq low
        chk("R1 irq", {31'b0, alarm_irq}, 32'h0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), b);
            chk("R1 reset read", {24'b0, b}, 32'h0);
        end

        // R7: alarm window readback
        set_alarm(32'hA1B2C3D4);
        rd32(4'hA, w);
        chk("R7 alarm readback", w, 32'hA1B2C3D4);

        // R2: control bits
        wr(4'h0, 8'hFF);
        rd(4'h0, b);
        chk("R2 ctrl ff", {24'b0, b}, 32'h82);
        wr(4'h0, 8'h7D);
        rd(4'h0, b);
        chk("R2 ctrl 7d", {24'b0, b}, 32'h00);

        // R3: ticks ignored while stopped
        set_time(32'h0000_0100);
        repeat (3) tick1();
        rd32(4'h6, w);
        chk("R3 stopped hold", w, 32'h0000_0100);

        // R5: staged upper bytes invisible until byte 0 write
        wr(4'h2, 8'h00);
        wr(4'h3, 8'h56);
        wr(4'h4, 8'h34);
        wr(4'h5, 8'h12);
        rd32(4'h6, w);
        chk("R5 staged invisible", w, 32'h0000_0100);
        wr(4'h2, 8'hFE);
        rd32(4'h6, w);
        chk("R5 commit", w, 32'h1234_56FE);

        // R3 R4: live counting with carry
        wr(4'h0, 8'h80);
        tick1();
        rd(4'h6, b);
        chk("R4 live low byte", {24'b0, b}, 32'hFF);
        tick1();
        rd(4'h6, b);
        chk("R4 low byte after carry", {24'b0, b}, 32'h00);
        rd32(4'h6, w);
        chk("R3 carry into byte1", w, 32'h1234_5700);

        // R3: carry sweep into each byte and wrap
        for (int k = 1; k <= 4; k++) begin
            start = (64'd1 << (8 * k)) - 64'd1;
            set_time(start[31:0]);
            tick1();
            rd32(4'h6, w);
            chk("R3 carry sweep", w, (k == 4) ? 32'h0 : 32'(64'd1 << (8 * k)));
        end

        // R11: writes to read window and reserved offsets ignored
        for (int a = 6; a < 10; a++) wr(4'(a), 8'hFF);
        wr(4'hE, 8'hFF);
        wr(4'hF, 8'hFF);
        rd32(4'h6, w);
        chk("R11 counter untouched", w, 32'h0);
        rd32(4'hA, w);
        chk("R11 alarm untouched", w, 32'hA1B2C3D4);
        rd(4'h0, b);
        chk("R11 ctrl untouched", {24'b0, b}, 32'h80);
        for (int a = 2; a < 6; a++) begin
            rd(4'(a), b);
            chk("R11 write window reads zero", {24'b0, b}, 32'h0);
        end
        rd(4'hE, b);
        chk("R11 reserved 0e", {24'b0, b}, 32'h0);
        rd(4'hF, b);
        chk("R11 reserved 0f", {24'b0, b}, 32'h0);

        // R10: alarm not armed
        set_alarm(32'h5);
        set_time(32'h4);
        tick1();
        idle(2);
        chk("R10 unarmed no irq", {31'b0, alarm_irq}, 32'h0);
        // R10: armed but clock stopped, counter parked on alarm
        wr(4'h0, 8'h02);
        idle(3);
        chk("R10 stopped no irq", {31'b0, alarm_irq}, 32'h0);
        rd(4'h1, b);
        chk("R10 status clear", {24'b0, b}, 32'h0);

        // R8: match sets status one edge later
        wr(4'h0, 8'h80);
        set_time(32'h3);
        wr(4'h0, 8'h82);
        tick1();
        chk("R8 no irq at 4", {31'b0, alarm_irq}, 32'h0);
        tick1();
        chk("R8 irq not yet on match cycle", {31'b0, alarm_irq}, 32'h0);
        idle(1);
        chk("R8 irq rises", {31'b0, alarm_irq}, 32'h1);
        rd(4'h1, b);
        chk("R8 status bit", {24'b0, b}, 32'h1);

        // R9: sticky, write of 1 no effect, write of 0 clears
        tick1();
        chk("R9 sticky", {31'b0, alarm_irq}, 32'h1);
        wr(4'h1, 8'h01);
        chk("R9 write one ignored", {31'b0, alarm_irq}, 32'h1);
        wr(4'h1, 8'hFE);
        chk("R9 clear", {31'b0, alarm_irq}, 32'h0);

        // R9: clear while match persists keeps status set
        wr(4'h0, 8'h80);
        set_time(32'h5);
        wr(4'h0, 8'h82);
        idle(1);
        chk("R9 re-fire", {31'b0, alarm_irq}, 32'h1);
        wr(4'h1, 8'h00);
        chk("R9 match beats clear", {31'b0, alarm_irq}, 32'h1);
        wr(4'h0, 8'h80);
        wr(4'h1, 8'h00);
        chk("R9 clear after disarm", {31'b0, alarm_irq}, 32'h0);

        // R6: load and tick in the same cycle
        wr(4'h3, 8'h00);
        wr(4'h4, 8'h00);
        wr(4'h5, 8'h00);
        sec_tick = 1'b1;
        wr(4'h2, 8'h40);
        sec_tick = 1'b0;
        rd32(4'h6, w);
        chk("R6 load wins", w, 32'h40);
        tick1();
        rd32(4'h6, w);
        chk("R6 tick after load", w, 32'h41);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule